// File: doc/BRIEF.md
# Signed Booth-Recoded Tree Multiplier for a Loop Phase Detector

This block forms the signed product of two 8-bit two's-complement samples. It serves as the phase detector of a digital phase-locked FM receiver, where one operand is the incoming modulated sample and the other is the locally synthesised oscillator sample. The product is the raw phase-error term that the loop filter smooths.

The multiplier operand is recoded in radix 4, which gives one partial-product row for every two multiplier bits. Each row is built by a small select-and-invert cell, with no sign bits replicated. A single constant row restores the signs and also carries the +1 terms of the negative rows. A carry-save tree reduces all rows to two, and a block carry-lookahead adder resolves those two into the 16-bit result.

Both operands are captured in input registers and the result is held in an output register. Each pair applied before a clock edge therefore appears at the output one edge later, and a new pair can be accepted on every cycle.

Top module: `bw_phase_mult`

## Requirements
- R1: `product` equals the two's-complement product of `mcand` and `mplier`, both read as signed 8-bit values, given as a 16-bit two's-complement word, for every one of the 65536 operand pairs.
- R2: The registered multiplier b is read in triplets (b[2i+1], b[2i], b[2i-1]) for i = 0..3, with b[-1] = 0. Triplet 000 or 111 gives digit 0, 001 or 010 gives +1, 011 gives +2, 100 gives -2, and 101 or 110 gives -1.
- R3: A row whose digit is negative is the bitwise inverse of the selected multiple (x or 2x), with a +1 injected at bit 2i of the correction row. A zero digit gives an all-zero multiple and no injection.
- R4: No row replicates its sign bit. Each 9-bit row has its top bit inverted, and one constant word corrects the total, so the extreme pairs are exact: -128 x -128 = 0x4000 and -128 x 127 = 0xC080.
- R5: The carry-save tree leaves two rows whose sum, modulo 2^16, equals the sum of the four partial-product rows and the correction row.
- R6: The carry-lookahead adder output equals the modulo-2^16 sum of the two rows left by the tree.
- R7: The result of a pair presented before clock edge k appears on `product` after edge k+1. After edge k it still shows the previous result.
- R8: While `rst_n` is low, the operand registers and `product` are zero, whatever the operand inputs are.
- R9: A different operand pair may be applied on every cycle. Each product then follows its own pair in order, with no cycle skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcand | input | 8 | Signed multiplicand (modulated input sample) |
| mplier | input | 8 | Signed multiplier (local oscillator sample), recoded in radix 4 |
| product | output | 16 | Signed product, registered |

## Verification
In every streaming cycle the operand registers take a new pair while the output register takes the product of the pair before. A fault in the pipelining can therefore put a stale or early result on the port. The bench feeds all 65536 pairs back to back, one per cycle, and compares each sample with the product of the pair applied two sampling points earlier. The same effect is provoked at reset release, where a pair already waits on the inputs: the first sample must still read zero and the next must read that pair's product.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // Carry into position k of a lookahead group, written as a flat sum of products
  function automatic logic la_carry(logic [15:0] g, logic [15:0] p, logic cin, int k);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < k; j++) begin
      term = g[j];
      for (int m = j + 1; m < k; m++) term = term & p[m];
      acc = acc | term;
    end
    term = cin;
    for (int m = 0; m < k; m++) term = term & p[m];
    return acc | term;
  endfunction

  // Rows left after one carry-save level
  function automatic int next_rows(int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  function automatic int tree_levels(int n);
    int lv;
    int r;
    lv = 0;
    r  = n;
    while (r > 2) begin
      r  = next_rows(r);
      lv = lv + 1;
    end
    return lv;
  endfunction

  function automatic int rows_at_level(int n, int l);
    int r;
    r = n;
    for (int i = 0; i < l; i++) r = next_rows(r);
    return r;
  endfunction

  // Constant that undoes the inverted top bit of every row (mod 2^(2w))
  function automatic logic [63:0] sign_fix(int w);
    logic [63:0] s;
    s = '0;
    for (int i = 0; i < w / 2; i++) s = s + (64'd1 << (w + 2 * i));
    return 64'd0 - s;
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode (
  input  logic [2:0] trip,
  output logic       sel_one,
  output logic       sel_two,
  output logic       neg
);
  // trip = {b[2i+1], b[2i], b[2i-1]}
  assign sel_one = trip[1] ^ trip[0];
  assign sel_two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
  assign neg     = trip[2] & ~(trip[1] & trip[0]);
endmodule

// File: rtl/booth_row.sv
module booth_row #(
  parameter int W   = 8,
  parameter int IDX = 0
) (
  input  logic [W-1:0]   x,
  input  logic           sel_one,
  input  logic           sel_two,
  input  logic           neg,
  output logic [2*W-1:0] row
);
  localparam int SH = 2 * IDX;

  logic [W:0] xs;   // x sign-extended by one bit
  logic [W:0] xd;   // 2x
  logic [W:0] p;

  assign xs = {x[W-1], x};
  assign xd = {x, 1'b0};

  for (genvar j = 0; j <= W; j++) begin : g_bit
    assign p[j] = ((sel_one & xs[j]) | (sel_two & xd[j])) ^ neg;
  end

  // top bit inverted instead of sign replication; correction row fixes the total
  assign row = {{(W-1){1'b0}}, ~p[W], p[W-1:0]} << SH;
endmodule

// File: rtl/csa3.sv
module csa3 #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] c,
  output logic [N-1:0] s,
  output logic [N-1:0] cy
);
  assign s  = a ^ b ^ c;
  assign cy = ((a & b) | (a & c) | (b & c)) << 1;
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int N   = 16,
  parameter int BLK = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum
);
  import bwm_pkg::*;

  localparam int NB = N / BLK;

  logic [N-1:0]  g;
  logic [N-1:0]  p;
  logic [N-1:0]  c;
  logic [NB-1:0] bg;
  logic [NB-1:0] bp;
  logic [NB-1:0] cblk;

  assign g = a & b;
  assign p = a ^ b;

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      bg[k] = la_carry(16'(g[k*BLK +: BLK]), 16'(p[k*BLK +: BLK]), 1'b0, BLK);
      bp[k] = &p[k*BLK +: BLK];
    end
    for (int k = 0; k < NB; k++) begin
      cblk[k] = la_carry(16'(bg), 16'(bp), 1'b0, k);
    end
    for (int k = 0; k < NB; k++) begin
      for (int j = 0; j < BLK; j++) begin
        c[k*BLK + j] = la_carry(16'(g[k*BLK +: BLK]), 16'(p[k*BLK +: BLK]), cblk[k], j);
      end
    end
  end

  assign sum = p ^ c;
endmodule

// File: rtl/bw_phase_mult.sv
module bw_phase_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product
);
  import bwm_pkg::*;

  localparam int PW   = 2 * W;
  localparam int NPP  = W / 2;
  localparam int NIN  = NPP + 1;
  localparam int NLEV = tree_levels(NIN);
  localparam logic [PW-1:0] CORR = PW'(sign_fix(W));

  logic [W-1:0]  a_q;
  logic [W-1:0]  b_q;
  logic [W:0]    b_ext;
  logic [2:0]    trip   [NPP];
  logic [NPP-1:0] one_v;
  logic [NPP-1:0] two_v;
  logic [NPP-1:0] neg_v;
  logic [PW-1:0] pp_row [NPP];
  logic [PW-1:0] corr_row;
  logic [PW-1:0] lv     [NLEV+1][NIN];
  logic [PW-1:0] sum_final;

  // operand registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= mcand;
      b_q <= mplier;
    end
  end

  assign b_ext = {b_q, 1'b0};

  // recoding and partial-product rows
  for (genvar i = 0; i < NPP; i++) begin : g_pp
    assign trip[i] = b_ext[2*i+2 -: 3];

    booth_recode u_enc (
      .trip    (trip[i]),
      .sel_one (one_v[i]),
      .sel_two (two_v[i]),
      .neg     (neg_v[i])
    );

    booth_row #(.W(W), .IDX(i)) u_row (
      .x       (a_q),
      .sel_one (one_v[i]),
      .sel_two (two_v[i]),
      .neg     (neg_v[i]),
      .row     (pp_row[i])
    );

    assign lv[0][i] = pp_row[i];

    AST_DIGIT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      ((two_v[i] ? 2 : (one_v[i] ? 1 : 0)) * (neg_v[i] ? -1 : 1)) ==
      (int'(trip[i][1]) + int'(trip[i][0]) - 2 * int'(trip[i][2])))
      else $error("digit mismatch"); // R2
    AST_NEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      neg_v[i] |-> (one_v[i] | two_v[i]))
      else $error("negation on zero digit"); // R3
  end

  // correction row: sign-fix constant plus the +1 of every negative row
  always_comb begin
    corr_row = CORR;
    for (int i = 0; i < NPP; i++) corr_row[2*i] = corr_row[2*i] | neg_v[i];
  end
  assign lv[0][NPP] = corr_row;

  // carry-save reduction tree
  for (genvar l = 0; l < NLEV; l++) begin : g_lvl
    localparam int NR = rows_at_level(NIN, l);
    localparam int NG = NR / 3;
    localparam int NL = NR % 3;
    localparam int NN = 2 * NG + NL;
    for (genvar g = 0; g < NG; g++) begin : g_csa
      csa3 #(.N(PW)) u_csa (
        .a  (lv[l][3*g]),
        .b  (lv[l][3*g+1]),
        .c  (lv[l][3*g+2]),
        .s  (lv[l+1][2*g]),
        .cy (lv[l+1][2*g+1])
      );
    end
    for (genvar k = 0; k < NL; k++) begin : g_pass
      assign lv[l+1][2*NG+k] = lv[l][3*NG+k];
    end
    for (genvar k = NN; k < NIN; k++) begin : g_zero
      assign lv[l+1][k] = '0;
    end
  end

  cla_adder #(.N(PW), .BLK(4)) u_cla (
    .a   (lv[NLEV][0]),
    .b   (lv[NLEV][1]),
    .sum (sum_final)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) product <= '0;
    else        product <= sum_final;
  end

  // ---------------- checks on internal events ----------------
  logic [PW-1:0] rows_total;
  logic [PW-1:0] tree_pair;
  logic [PW-1:0] a_wide;
  logic [PW-1:0] b_wide;

  always_comb begin
    rows_total = '0;
    for (int i = 0; i < NIN; i++) rows_total = rows_total + lv[0][i];
  end
  assign tree_pair = lv[NLEV][0] + lv[NLEV][1];
  assign a_wide    = {{W{a_q[W-1]}}, a_q};
  assign b_wide    = {{W{b_q[W-1]}}, b_q};

  AST_TREE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    tree_pair == rows_total) else $error("tree sum"); // R5
  AST_CLA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    sum_final == tree_pair) else $error("adder sum"); // R6
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> product == $past(a_wide * b_wide)) else $error("product latency"); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> product == '0) else $error("reset value"); // R8

endmodule

// File: tb/test_bw_phase_mult.sv
module test_bw_phase_mult;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mcand = '0;
  logic [7:0]  mplier = '0;
  logic [15:0] product;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  bw_phase_mult i_bw_phase_mult (
    .clk     (clk),
    .rst_n   (rst_n),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
  );

  // {mcand, mplier, expected product}, worked out by hand
  localparam logic [31:0] VEC [14] = '{
    32'h0000_0000, // 0 x 0
    32'h0101_0001, // 1 x 1
    32'h7F7F_3F01, // 127 x 127
    32'h8080_4000, // -128 x -128 (R4)
    32'h807F_C080, // -128 x 127 (R4)
    32'hFFFF_0001, // -1 x -1
    32'hFF01_FFFF, // -1 x 1
    32'h8001_FF80, // -128 x 1
    32'h0305_000F, // 3 x 5
    32'hFD05_FFF1, // -3 x 5
    32'h55AA_E372, // 85 x -86, alternating triplets (R2)
    32'h40FE_FF80, // 64 x -2
    32'h1234_03A8, // 18 x 52
    32'hC33C_F1B4  // -61 x 60
  };

  function automatic logic [15:0] ref_mul(logic [7:0] a, logic [7:0] b);
    int ai;
    int bi;
    ai = a[7] ? int'(a) - 256 : int'(a);
    bi = b[7] ? int'(b) - 256 : int'(b);
    return 16'(ai * bi);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: product=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    // R8: reset holds output at zero while operands toggle
    mcand  = 8'h5A;
    mplier = 8'hC3;
    repeat (3) @(negedge clk);
    check("R8", product, 16'h0000);
    mcand = 8'h7F;
    @(negedge clk);
    check("R8", product, 16'h0000);

    // R7: release with a pair waiting on the inputs
    mcand  = 8'h5A;
    mplier = 8'hC3;
    rst_n  = 1'b1;
    @(negedge clk);
    check("R7", product, 16'h0000);
    @(negedge clk);
    check("R7", product, 16'hEA8E); // 90 x -61

    // R1 / R2 / R4: table walk
    for (int v = 0; v < 14; v++) begin
      mcand  = VEC[v][31:24];
      mplier = VEC[v][23:16];
      @(negedge clk);
      @(negedge clk);
      check(v == 3 || v == 4 ? "R4" : (v == 10 ? "R2" : "R1"), product, VEC[v][15:0]);
    end

    // R9 / R1 / R3: every pair, one per cycle
    for (int i = 0; i < 65538; i++) begin
      @(negedge clk);
      if (i >= 2) check("R9", product, ref_mul(8'((i - 2) >> 8), 8'((i - 2) & 255)));
      if (i < 65536) begin
        mcand  = 8'(i >> 8);
        mplier = 8'(i & 255);
      end
    end

    // R8: reset in the middle of traffic
    mcand  = 8'h80;
    mplier = 8'h80;
    @(negedge clk);
    @(negedge clk);
    check("R3", product, 16'h4000);
    rst_n = 1'b0;
    #1;
    check("R8", product, 16'h0000);
    @(negedge clk);
    check("R8", product, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", product, 16'h4000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: product=%h expected=finished run", product);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule